// File: doc/BRIEF.md
# Complex Q1.15 Requantizer with ADC Bypass

This block sits at the output of a receive channelizer. It takes complex samples with 25-bit signed rails and 23 fractional bits and reduces each rail to signed 16-bit Q1.15. Each rail is rounded to nearest, with ties going toward positive infinity, and is clamped to the Q1.15 range instead of wrapping. The two results are packed into one 32-bit word, so a complex sample needs 32 bits rather than 50.

A mode input picks the source. In channel mode the requantized channelizer sample goes out. In bypass mode a raw 16-bit ADC code, which is already Q1.15, goes out with its stored integer unchanged, and the imaginary half of the word is zero. One register stage sits between the inputs and the outputs. The output valid strobe follows that same stage. A sticky flag records that a clamp has happened at least once since reset.

Top module: `cplx_requant_top`

## Requirements
- R1: After reset, out_valid, out_word and sat_flag are all zero.
- R2: out_valid equals in_valid delayed by exactly one clock.
- R3: In channel mode (mode_bypass=0), a valid sample appears one clock later with the real result in out_word[31:16] and the imaginary result in out_word[15:0]. Each rail result is floor((x+128)/256) taken as a 16-bit two's complement value, where x is the signed 25-bit input code.
- R4: A rail whose rounded value exceeds 32767 outputs 0x7FFF.
- R5: A rail whose rounded value is below -32768 outputs 0x8000. A rounded value of exactly -32768 passes through without clamping.
- R6: Rounding is half-up. Input codes 128, 127, -128 and -129 give 1, 0, 0 and -1.
- R7: In bypass mode (mode_bypass=1), a valid sample gives out_word = {adc_sample, 16'h0000} one clock later. The channel rails are ignored: their values affect neither out_word nor sat_flag.
- R8: sat_flag rises in the same clock that out_valid presents a channel-mode sample in which either rail clamped. It then stays high until reset.
- R9: While in_valid is low, out_word keeps its value and sat_flag does not change, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_bypass | input | 1 | 1 selects the raw ADC code, 0 selects the requantized channel sample |
| in_valid | input | 1 | Input sample strobe |
| chan_re | input | 25 | Channel real rail, signed, 23 fractional bits |
| chan_im | input | 25 | Channel imaginary rail, signed, 23 fractional bits |
| adc_sample | input | 16 | Raw ADC code, Q1.15 |
| out_valid | output | 1 | Output sample strobe |
| out_word | output | 32 | Packed complex result, real in [31:16], imaginary in [15:0] |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
The properties assume that in_valid and mode_bypass are sampled only at rising edges and keep a known value during reset. The bench meets this by driving every input on the falling edge and holding in_valid low through reset. The bypass properties also assume that mode_bypass qualifies the same cycle as in_valid, and the bench always changes the two together. The random channel patterns are confined to codes that cannot clamp, so the flag stays clear until the directed saturation scenarios set it on purpose.

// File: rtl/cplx_requant_pkg.sv
package cplx_requant_pkg;
   localparam int unsigned SRC_W    = 25;
   localparam int unsigned SRC_FRAC = 23;
   localparam int unsigned DST_W    = 16;
   localparam int unsigned DST_FRAC = 15;

   typedef enum logic {
      SRC_CHANNEL = 1'b0,
      SRC_ADC     = 1'b1
   } src_sel_e;
endpackage

// File: rtl/rail_requant.sv
module rail_requant #(
   parameter int unsigned IN_W     = 25,
   parameter int unsigned IN_FRAC  = 23,
   parameter int unsigned OUT_W    = 16,
   parameter int unsigned OUT_FRAC = 15
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout,
   output logic             clip
);
   localparam int unsigned SH = IN_FRAC - OUT_FRAC;
   localparam int unsigned EW = IN_W + 1;
   localparam int unsigned RW = EW - SH;
   localparam int unsigned HW = RW - OUT_W + 1;

   localparam logic [OUT_W-1:0] Q_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] Q_MIN = {1'b1, {(OUT_W-1){1'b0}}};

   logic [EW-1:0] ext;
   logic [RW-1:0] scaled;
   logic [HW-1:0] head;

   assign ext = {din[IN_W-1], din};

   generate
      if (SH > 0) begin : g_round
         localparam logic [EW-1:0] BIAS = EW'(1) << (SH - 1);
         logic [EW-1:0] biased;
         assign biased = ext + BIAS;
         assign scaled = biased[EW-1:SH];
      end else begin : g_noround
         assign scaled = ext;
      end
   endgenerate

   assign head = scaled[RW-1:OUT_W-1];

   always_comb begin
      clip = !((&head) || (~|head));
      if (clip) begin
         dout = scaled[RW-1] ? Q_MIN : Q_MAX;
      end else begin
         dout = scaled[OUT_W-1:0];
      end
   end
endmodule

// File: rtl/requant_out_stage.sv
module requant_out_stage #(
   parameter int unsigned OUT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               sel_adc,
   input  logic [OUT_W-1:0]   q_re,
   input  logic [OUT_W-1:0]   q_im,
   input  logic               clip_re,
   input  logic               clip_im,
   input  logic [OUT_W-1:0]   adc_code,
   output logic               out_valid,
   output logic [2*OUT_W-1:0] out_word,
   output logic               sat_flag
);
   logic [2*OUT_W-1:0] next_word;
   logic               hit;

   always_comb begin
      if (sel_adc) begin
         next_word = {adc_code, {OUT_W{1'b0}}};
      end else begin
         next_word = {q_re, q_im};
      end
      hit = in_valid && !sel_adc && (clip_re || clip_im);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= next_word;
         end
         if (hit) begin
            sat_flag <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cplx_requant_top.sv
module cplx_requant_top
   import cplx_requant_pkg::*;
#(
   parameter int unsigned IN_W     = SRC_W,
   parameter int unsigned IN_FRAC  = SRC_FRAC,
   parameter int unsigned OUT_W    = DST_W,
   parameter int unsigned OUT_FRAC = DST_FRAC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_bypass,
   input  logic                 in_valid,
   input  logic [IN_W-1:0]      chan_re,
   input  logic [IN_W-1:0]      chan_im,
   input  logic [OUT_W-1:0]     adc_sample,
   output logic                 out_valid,
   output logic [2*OUT_W-1:0]   out_word,
   output logic                 sat_flag
);
   generate
      if (IN_FRAC < OUT_FRAC) begin : g_bad_frac
         $error("input fraction bits must not be fewer than output fraction bits");
      end
      if ((IN_W - IN_FRAC) < (OUT_W - OUT_FRAC)) begin : g_bad_int
         $error("input integer bits must not be fewer than output integer bits");
      end
      if (OUT_W < 2) begin : g_bad_w
         $error("output width too small");
      end
   endgenerate

   localparam int unsigned NRAIL = 2;

   logic [IN_W-1:0]  rail_in   [NRAIL];
   logic [OUT_W-1:0] rail_q    [NRAIL];
   logic             rail_clip [NRAIL];
   src_sel_e         sel;

   assign rail_in[0] = chan_re;
   assign rail_in[1] = chan_im;
   assign sel = src_sel_e'(mode_bypass);

   for (genvar i = 0; i < NRAIL; i++) begin : g_rail
      rail_requant #(
         .IN_W     (IN_W),
         .IN_FRAC  (IN_FRAC),
         .OUT_W    (OUT_W),
         .OUT_FRAC (OUT_FRAC)
      ) u_rail (
         .din  (rail_in[i]),
         .dout (rail_q[i]),
         .clip (rail_clip[i])
      );
   end

   requant_out_stage #(
      .OUT_W (OUT_W)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .sel_adc   (sel == SRC_ADC),
      .q_re      (rail_q[0]),
      .q_im      (rail_q[1]),
      .clip_re   (rail_clip[0]),
      .clip_im   (rail_clip[1]),
      .adc_code  (adc_sample),
      .out_valid (out_valid),
      .out_word  (out_word),
      .sat_flag  (sat_flag)
   );
endmodule

// File: rtl/cplx_requant_chk.sv
module cplx_requant_chk #(
   parameter int unsigned OUT_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mode_bypass,
   input logic               in_valid,
   input logic [OUT_W-1:0]   adc_sample,
   input logic               out_valid,
   input logic [2*OUT_W-1:0] out_word,
   input logic               sat_flag
);
   p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> $stable(out_word));

   p_hold_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> $stable(sat_flag));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sat_flag |=> sat_flag);

   p_bypass_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && $past(mode_bypass)) |->
         (out_word == {$past(adc_sample), {OUT_W{1'b0}}}));

   p_bypass_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && $past(mode_bypass) && !$past(sat_flag))
         |-> !sat_flag);

   p_flag_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_flag) |-> out_valid);
endmodule

bind cplx_requant_top cplx_requant_chk #(.OUT_W(OUT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_bypass (mode_bypass),
   .in_valid    (in_valid),
   .adc_sample  (adc_sample),
   .out_valid   (out_valid),
   .out_word    (out_word),
   .sat_flag    (sat_flag)
);

// File: tb/cplx_requant_top_test.sv
module cplx_requant_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_bypass = 1'b0;
   logic        in_valid = 1'b0;
   logic [24:0] chan_re = '0;
   logic [24:0] chan_im = '0;
   logic [15:0] adc_sample = '0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        sat_flag;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   cplx_requant_top uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_bypass (mode_bypass),
      .in_valid    (in_valid),
      .chan_re     (chan_re),
      .chan_im     (chan_im),
      .adc_sample  (adc_sample),
      .out_valid   (out_valid),
      .out_word    (out_word),
      .sat_flag    (sat_flag)
   );

   function automatic logic [15:0] exp_rail(int x);
      int r;
      r = (x + 128) >>> 8;
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r[15:0];
   endfunction

   function automatic bit clips(int x);
      int r;
      r = (x + 128) >>> 8;
      return (r > 32767) || (r < -32768);
   endfunction

   task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_chan(int re, int im);
      @(negedge clk);
      mode_bypass = 1'b0;
      in_valid = 1'b1;
      chan_re = re[24:0];
      chan_im = im[24:0];
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_r1();
      check32("R1 out_valid", {31'b0, out_valid}, 32'd0);
      check32("R1 out_word", out_word, 32'd0);
      check32("R1 sat_flag", {31'b0, sat_flag}, 32'd0);
   endtask

   task automatic t_round_r6();
      int vals [4] = '{128, 127, -128, -129};
      logic [15:0] want [4] = '{16'h0001, 16'h0000, 16'h0000, 16'hFFFF};
      for (int i = 0; i < 4; i++) begin
         send_chan(vals[i], vals[3-i]);
         check32("R6 round", out_word, {want[i], want[3-i]});
         check32("R2 valid", {31'b0, out_valid}, 32'd1);
      end
   endtask

   task automatic t_patterns_r3();
      for (int i = 0; i < 40; i++) begin
         int re = int'($urandom_range(16777000)) - 8388736;
         int im = int'($urandom_range(16777000)) - 8388736;
         send_chan(re, im);
         check32("R3 pack", out_word, {exp_rail(re), exp_rail(im)});
      end
      check32("R3 no flag", {31'b0, sat_flag}, 32'd0);
   endtask

   task automatic t_bypass_r7();
      logic [15:0] codes [3] = '{16'h8000, 16'h7FFF, 16'h1234};
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         mode_bypass = 1'b1;
         in_valid = 1'b1;
         adc_sample = codes[i];
         chan_re = 25'h0FFFFFF;
         chan_im = 25'h1000000;
         @(negedge clk);
         in_valid = 1'b0;
         check32("R7 bypass word", out_word, {codes[i], 16'h0000});
         check32("R7 bypass flag", {31'b0, sat_flag}, 32'd0);
      end
      mode_bypass = 1'b0;
   endtask

   task automatic t_hold_r9();
      logic [31:0] prev;
      prev = out_word;
      @(negedge clk);
      in_valid = 1'b0;
      mode_bypass = 1'b0;
      chan_re = 25'h0FFFFFF;
      chan_im = 25'h1000000;
      adc_sample = 16'h5555;
      repeat (3) @(negedge clk);
      check32("R9 hold word", out_word, prev);
      check32("R9 hold flag", {31'b0, sat_flag}, 32'd0);
      check32("R2 idle valid", {31'b0, out_valid}, 32'd0);
   endtask

   task automatic t_sat_pos_r4();
      send_chan(16777215, 8388480);
      check32("R4 positive clamp", out_word, 32'h7FFF_7FFF);
      check32("R8 flag set", {31'b0, sat_flag}, 32'd1);
      send_chan(8388479, 0);
      check32("R4 max no clamp", out_word, 32'h7FFF_0000);
   endtask

   task automatic t_sat_neg_r5();
      send_chan(-16777216, -8388737);
      check32("R5 negative clamp", out_word, 32'h8000_8000);
      send_chan(-8388736, 256);
      check32("R5 min exact", out_word, 32'h8000_0001);
      check32("R8 flag sticky", {31'b0, sat_flag}, 32'd1);
   endtask

   task automatic t_flag_imag_r8();
      do_reset();
      check32("R1 flag cleared", {31'b0, sat_flag}, 32'd0);
      send_chan(256, -16777216);
      check32("R8 imag clip word", out_word, 32'h0001_8000);
      check32("R8 imag clip flag", {31'b0, sat_flag}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_round_r6();
      t_patterns_r3();
      t_bypass_r7();
      t_hold_r9();
      t_sat_pos_r4();
      t_sat_neg_r5();
      t_flag_imag_r8();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vectors++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule